// File: doc/BRIEF.md
# Packet Buffer Allocation Unit

This block does the bookkeeping for a shared packet RAM that is cut into fixed-size pages. The host asks it for room for a packet of some byte length. The block answers with a packet number, which is the handle the host uses for that packet from then on. Storage is counted per packet number. No page addresses leave the block. The packet data RAM, the byte access path into it and the MAC are all outside this block.

The host works through a two-bit command port and a packet-number register. It can allocate, release, queue a packet for transmit, or acknowledge a transmit completion. Queued packet numbers are handed to the MAC through a valid/ready handshake, and only while transmit is enabled. The MAC reports each finished packet together with a success bit. Reported packets go into a completion queue, and the host reads its head and pops it. When auto-release is on, a packet that was sent successfully gives its pages back directly and never appears in the completion queue. A failed send always reaches the completion queue and also stops transmission until the host enables it again.

Top module: `pkt_alloc_unit`

## Requirements
- R1: After reset the following hold: allocFlag, allocBusy, txEn, macValid and txFlag are 0; allocResult is all ones; freePages equals the page total (32); compEmpty and txqEmpty are 1; compHead reads all ones.
- R2: Command codes on cmdOp, taken when cmdValid is high, are: 0 allocate, 1 release, 2 enqueue, 3 transmit acknowledge. An allocate of cmdLen bytes needs ceil(cmdLen/256) pages, and a length of 0 counts as one page. When enough pages and a packet number are free, the grant happens on the clock edge after the command. At that edge allocFlag is set, allocResult takes the lowest unused packet number, and freePages drops by the page count.
- R3: An allocate that cannot be served holds allocBusy high with allocFlag low, and is retried every cycle until a release makes room. An allocate issued while busy is ignored.
- R4: Release returns every page held by the packet number in pnReg, which is loaded through pnWe/pnWdata. Releasing a packet number that is not in use leaves freePages unchanged.
- R5: Enqueue appends pnReg to the transmit queue. macValid is high only when txEn is 1 and the queue is not empty. macPkt shows the oldest entry, and a cycle with both macValid and macReady high removes it.
- R6: A reported completion that is not auto-released appends macDonePkt to the completion queue. txFlag is 1 exactly when that queue is not empty. compHead shows the oldest entry, and an empty queue reads all ones.
- R7: Transmit acknowledge removes the head of the completion queue. On an empty queue it has no effect.
- R8: While autoRelease is 1, a successful completion frees that packet's pages and adds no completion entry.
- R9: A failed completion clears txEn and is always added to the completion queue. A txEnSet pulse sets txEn again.
- R10: allocIrq is allocFlag AND allocMask, and txIrq is txFlag AND txMask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command strobe |
| cmdOp | input | 2 | Command code |
| cmdLen | input | 13 | Byte length for allocate |
| pnWe | input | 1 | Load the packet-number register |
| pnWdata | input | 4 | Packet number to load |
| txEnSet | input | 1 | Pulse that enables transmit |
| autoRelease | input | 1 | Free pages on successful send |
| allocMask | input | 1 | Allocation interrupt enable |
| txMask | input | 1 | Transmit interrupt enable |
| macReady | input | 1 | MAC accepts the offered packet |
| macDone | input | 1 | MAC completion report strobe |
| macDonePkt | input | 4 | Packet number being reported |
| macDoneOk | input | 1 | Report is a successful send |
| allocResult | output | 4 | Last granted packet number |
| allocFlag | output | 1 | Allocation completed |
| allocBusy | output | 1 | Allocation waiting for space |
| allocIrq | output | 1 | Masked allocation interrupt |
| freePages | output | 6 | Pages currently free |
| txEn | output | 1 | Transmit enable |
| macValid | output | 1 | Packet offered to MAC |
| macPkt | output | 4 | Packet number offered to MAC |
| txFlag | output | 1 | Completion queue not empty |
| txIrq | output | 1 | Masked transmit interrupt |
| compHead | output | 4 | Oldest completion entry |
| compEmpty | output | 1 | Completion queue empty |
| txqEmpty | output | 1 | Transmit queue empty |

## Verification
The hardest state to reach is an allocation held pending while another allocate arrives and a release then frees room. The bench first takes one page. It then asks for all 32 pages, which cannot be served, and sends a one-page allocate while the first request is still waiting. After that it releases the first packet. The retried grant has to bring freePages to exactly zero, and that value shows that the ignored request did not replace the pending one. Auto-release and failure reporting are reached by driving the MAC report pins directly against packets that the host allocated.

// File: rtl/pau_pkg.sv
package pau_pkg;
  typedef enum logic [1:0] {
    OP_ALLOC   = 2'd0,
    OP_RELEASE = 2'd1,
    OP_ENQUEUE = 2'd2,
    OP_TXACK   = 2'd3
  } cmdOp_e;

  // strobes issued by control to the datapath
  typedef struct packed {
    logic allocReq;
    logic hostRel;
    logic autoRel;
    logic pushTx;
    logic popTx;
    logic pushComp;
    logic popComp;
  } strobes_t;
endpackage

// File: rtl/pau_fifo.sv
module pau_fifo #(
  parameter int W     = 4,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         push,
  input  logic [W-1:0] pushData,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [AW:0]   count;

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= (wrPtr == AW'(DEPTH-1)) ? '0 : wrPtr + 1'b1;
      if (pop)  rdPtr <= (rdPtr == AW'(DEPTH-1)) ? '0 : rdPtr + 1'b1;
      count <= count + (AW+1)'(push) - (AW+1)'(pop);
    end
  end

  assign empty = (count == '0);
  assign full  = (count == (AW+1)'(DEPTH));
  assign head  = empty ? '1 : mem[rdPtr];

  AST_NO_OVERFLOW:  assert property (@(posedge clk) disable iff (!rstN) push |-> !full);  // R5
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN) pop |-> !empty);  // R7
endmodule

// File: rtl/pau_datapath.sv
module pau_datapath
  import pau_pkg::*;
#(
  parameter int NUM_PKTS   = 16,
  parameter int NUM_PAGES  = 32,
  parameter int PAGE_BYTES = 256,
  parameter int QDEPTH     = 16,
  parameter int LEN_W      = 13,
  localparam int PN_W      = $clog2(NUM_PKTS),
  localparam int CNT_W     = $clog2(NUM_PAGES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobes_t         stb,
  input  logic [LEN_W-1:0] cmdLen,
  input  logic [PN_W-1:0]  pnReg,
  input  logic [PN_W-1:0]  macDonePkt,
  output logic [PN_W-1:0]  allocResult,
  output logic             allocFlag,
  output logic             allocBusy,
  output logic [CNT_W-1:0] freePages,
  output logic [PN_W-1:0]  txHead,
  output logic             txEmpty,
  output logic             txFull,
  output logic [PN_W-1:0]  compHead,
  output logic             compEmpty,
  output logic             compFull
);
  localparam int PSH = $clog2(PAGE_BYTES);
  localparam int SW  = CNT_W + 2;

  logic [NUM_PKTS-1:0] pktUsed;
  logic [CNT_W-1:0]    pageCnt [NUM_PKTS];
  logic [CNT_W-1:0]    freeCount, pendPages, reqPages;
  logic [LEN_W:0]      rounded;
  logic [PN_W-1:0]     freePn;
  logic                anyFree, grant, relHost, relAuto;
  logic [SW-1:0]       freeNext;

  // pages needed for the requested length, zero length takes one page
  always_comb begin
    rounded  = {1'b0, cmdLen} + (LEN_W+1)'(PAGE_BYTES - 1);
    reqPages = CNT_W'(rounded >> PSH);
    if (reqPages == '0) reqPages = CNT_W'(1);
  end

  // lowest packet number not in use
  always_comb begin
    freePn  = '0;
    anyFree = 1'b0;
    for (int i = NUM_PKTS - 1; i >= 0; i--) begin
      if (!pktUsed[i]) begin
        freePn  = PN_W'(i);
        anyFree = 1'b1;
      end
    end
  end

  assign grant   = allocBusy && anyFree && (freeCount >= pendPages);
  assign relHost = stb.hostRel && pktUsed[pnReg];
  assign relAuto = stb.autoRel && pktUsed[macDonePkt] && !(relHost && pnReg == macDonePkt);

  always_comb begin
    freeNext = SW'(freeCount);
    if (relHost) freeNext = freeNext + SW'(pageCnt[pnReg]);
    if (relAuto) freeNext = freeNext + SW'(pageCnt[macDonePkt]);
    if (grant)   freeNext = freeNext - SW'(pendPages);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pktUsed     <= '0;
      freeCount   <= CNT_W'(NUM_PAGES);
      pendPages   <= '0;
      allocBusy   <= 1'b0;
      allocFlag   <= 1'b0;
      allocResult <= '1;
      for (int i = 0; i < NUM_PKTS; i++) pageCnt[i] <= '0;
    end else begin
      freeCount <= freeNext[CNT_W-1:0];
      if (relHost) pktUsed[pnReg] <= 1'b0;
      if (relAuto) pktUsed[macDonePkt] <= 1'b0;
      if (grant) begin
        pktUsed[freePn] <= 1'b1;
        pageCnt[freePn] <= pendPages;
        allocResult     <= freePn;
        allocFlag       <= 1'b1;
        allocBusy       <= 1'b0;
      end else if (stb.allocReq && !allocBusy) begin
        pendPages <= reqPages;
        allocBusy <= 1'b1;
        allocFlag <= 1'b0;
      end
    end
  end

  assign freePages = freeCount;

  AST_FREE_BOUND: assert property (@(posedge clk) disable iff (!rstN) freeCount <= CNT_W'(NUM_PAGES)); // R4
  AST_GRANT_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rstN) $rose(allocFlag) |-> $past(allocBusy)); // R2
  AST_BUSY_NO_FLAG: assert property (@(posedge clk) disable iff (!rstN) allocBusy |-> !allocFlag); // R3

  pau_fifo #(.W(PN_W), .DEPTH(QDEPTH)) i_txq (
    .clk(clk), .rstN(rstN), .push(stb.pushTx), .pushData(pnReg),
    .pop(stb.popTx), .head(txHead), .empty(txEmpty), .full(txFull)
  );

  pau_fifo #(.W(PN_W), .DEPTH(QDEPTH)) i_compq (
    .clk(clk), .rstN(rstN), .push(stb.pushComp), .pushData(macDonePkt),
    .pop(stb.popComp), .head(compHead), .empty(compEmpty), .full(compFull)
  );
endmodule

// File: rtl/pau_ctrl.sv
module pau_ctrl
  import pau_pkg::*;
#(
  parameter int PN_W = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cmdValid,
  input  logic [1:0]      cmdOp,
  input  logic            pnWe,
  input  logic [PN_W-1:0] pnWdata,
  input  logic            txEnSet,
  input  logic            autoRelease,
  input  logic            macReady,
  input  logic            macDone,
  input  logic            macDoneOk,
  input  logic            txEmpty,
  input  logic            txFull,
  input  logic            compEmpty,
  input  logic            compFull,
  output strobes_t        stb,
  output logic [PN_W-1:0] pnReg,
  output logic            txEn,
  output logic            macValid
);
  cmdOp_e op;
  logic   okAuto;

  assign op       = cmdOp_e'(cmdOp);
  assign okAuto   = macDoneOk && autoRelease;
  assign macValid = txEn && !txEmpty;

  always_comb begin
    stb          = '0;
    stb.allocReq = cmdValid && (op == OP_ALLOC);
    stb.hostRel  = cmdValid && (op == OP_RELEASE);
    stb.pushTx   = cmdValid && (op == OP_ENQUEUE) && !txFull;
    stb.popComp  = cmdValid && (op == OP_TXACK) && !compEmpty;
    stb.popTx    = macValid && macReady;
    stb.autoRel  = macDone && okAuto;
    stb.pushComp = macDone && !okAuto && !compFull;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pnReg <= '0;
      txEn  <= 1'b0;
    end else begin
      if (pnWe) pnReg <= pnWdata;
      if (macDone && !macDoneOk) txEn <= 1'b0;
      else if (txEnSet)          txEn <= 1'b1;
    end
  end

  AST_TXEN_DROP: assert property (@(posedge clk) disable iff (!rstN) (macDone && !macDoneOk) |=> !txEn); // R9
  AST_TXEN_RISE: assert property (@(posedge clk) disable iff (!rstN) $rose(txEn) |-> $past(txEnSet)); // R9
endmodule

// File: rtl/pkt_alloc_unit.sv
module pkt_alloc_unit
  import pau_pkg::*;
#(
  parameter int NUM_PKTS   = 16,
  parameter int NUM_PAGES  = 32,
  parameter int PAGE_BYTES = 256,
  parameter int QDEPTH     = 16,
  parameter int LEN_W      = 13,
  localparam int PN_W      = $clog2(NUM_PKTS),
  localparam int CNT_W     = $clog2(NUM_PAGES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [1:0]       cmdOp,
  input  logic [LEN_W-1:0] cmdLen,
  input  logic             pnWe,
  input  logic [PN_W-1:0]  pnWdata,
  input  logic             txEnSet,
  input  logic             autoRelease,
  input  logic             allocMask,
  input  logic             txMask,
  input  logic             macReady,
  input  logic             macDone,
  input  logic [PN_W-1:0]  macDonePkt,
  input  logic             macDoneOk,
  output logic [PN_W-1:0]  allocResult,
  output logic             allocFlag,
  output logic             allocBusy,
  output logic             allocIrq,
  output logic [CNT_W-1:0] freePages,
  output logic             txEn,
  output logic             macValid,
  output logic [PN_W-1:0]  macPkt,
  output logic             txFlag,
  output logic             txIrq,
  output logic [PN_W-1:0]  compHead,
  output logic             compEmpty,
  output logic             txqEmpty
);
  strobes_t        stb;
  logic [PN_W-1:0] pnReg;
  logic            txFull, compFull;

  pau_ctrl #(.PN_W(PN_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .pnWe(pnWe), .pnWdata(pnWdata), .txEnSet(txEnSet), .autoRelease(autoRelease),
    .macReady(macReady), .macDone(macDone), .macDoneOk(macDoneOk),
    .txEmpty(txqEmpty), .txFull(txFull), .compEmpty(compEmpty), .compFull(compFull),
    .stb(stb), .pnReg(pnReg), .txEn(txEn), .macValid(macValid)
  );

  pau_datapath #(
    .NUM_PKTS(NUM_PKTS), .NUM_PAGES(NUM_PAGES), .PAGE_BYTES(PAGE_BYTES),
    .QDEPTH(QDEPTH), .LEN_W(LEN_W)
  ) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cmdLen(cmdLen), .pnReg(pnReg),
    .macDonePkt(macDonePkt), .allocResult(allocResult), .allocFlag(allocFlag),
    .allocBusy(allocBusy), .freePages(freePages), .txHead(macPkt),
    .txEmpty(txqEmpty), .txFull(txFull), .compHead(compHead),
    .compEmpty(compEmpty), .compFull(compFull)
  );

  assign txFlag   = !compEmpty;
  assign allocIrq = allocFlag && allocMask;
  assign txIrq    = txFlag && txMask;
endmodule

// File: tb/test_pkt_alloc_unit.sv
module test_pkt_alloc_unit;
  logic clk = 1'b0, rstN = 1'b0;
  logic cmdValid = 0, pnWe = 0, txEnSet = 0, autoRelease = 0, allocMask = 0, txMask = 0;
  logic macReady = 0, macDone = 0, macDoneOk = 0;
  logic [1:0]  cmdOp = 0;
  logic [12:0] cmdLen = 0;
  logic [3:0]  pnWdata = 0, macDonePkt = 0;
  logic [3:0]  allocResult, macPkt, compHead;
  logic [5:0]  freePages;
  logic allocFlag, allocBusy, allocIrq, txEn, macValid, txFlag, txIrq, compEmpty, txqEmpty;
  int nChecks = 0, nFails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  pkt_alloc_unit i_pkt_alloc_unit (.*);

  localparam int NV = 6;
  localparam int VEC_LEN   [NV] = '{1, 256, 257, 0, 512, 1000};
  localparam int VEC_PAGES [NV] = '{1, 1, 2, 1, 2, 4};

  task automatic chk(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cmd(int op, int len);
    @(negedge clk); cmdValid = 1; cmdOp = 2'(op); cmdLen = 13'(len);
    @(negedge clk); cmdValid = 0;
  endtask

  task automatic setPn(int pn);
    @(negedge clk); pnWe = 1; pnWdata = 4'(pn);
    @(negedge clk); pnWe = 0;
  endtask

  task automatic report(int pn, bit ok);
    @(negedge clk); macDone = 1; macDonePkt = 4'(pn); macDoneOk = ok;
    @(negedge clk); macDone = 0;
  endtask

  initial begin
    int used;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 allocFlag", allocFlag, 0);
    chk("R1 allocBusy", allocBusy, 0);
    chk("R1 allocResult", allocResult, 15);
    chk("R1 freePages", freePages, 32);
    chk("R1 txEn", txEn, 0);
    chk("R1 macValid", macValid, 0);
    chk("R1 compEmpty", compEmpty, 1);
    chk("R1 txqEmpty", txqEmpty, 1);
    chk("R1 compHead", compHead, 15);
    chk("R1 txFlag", txFlag, 0);

    // R2 table of allocation sizes
    used = 0;
    for (int i = 0; i < NV; i++) begin
      cmd(0, VEC_LEN[i]);
      chk("R2 busy before grant", allocBusy, 1);
      @(negedge clk);
      used += VEC_PAGES[i];
      chk("R2 allocFlag", allocFlag, 1);
      chk("R2 allocResult", allocResult, i);
      chk("R2 freePages", freePages, 32 - used);
    end
    // R10 allocation interrupt mask
    allocMask = 1; #1; chk("R10 allocIrq on", allocIrq, 1);
    allocMask = 0; #1; chk("R10 allocIrq off", allocIrq, 0);
    // R4 release everything
    for (int i = 0; i < NV; i++) begin
      setPn(i); cmd(1, 0);
    end
    chk("R4 all pages back", freePages, 32);
    setPn(9); cmd(1, 0);
    chk("R4 unused release", freePages, 32);

    // R3 pending allocation
    cmd(0, 256); @(negedge clk);
    chk("R3 first grant", freePages, 31);
    cmd(0, 8000); @(negedge clk);
    chk("R3 busy waits", allocBusy, 1);
    chk("R3 flag low while waiting", allocFlag, 0);
    cmd(0, 256);
    chk("R3 still busy", allocBusy, 1);
    chk("R3 ignored alloc keeps pages", freePages, 31);
    setPn(0); cmd(1, 0);
    @(negedge clk);
    chk("R3 retried grant flag", allocFlag, 1);
    chk("R3 retried grant number", allocResult, 0);
    chk("R3 retried grant pages", freePages, 0);
    cmd(1, 0);
    chk("R4 release big packet", freePages, 32);

    // R5 transmit queue and MAC handshake
    setPn(5); cmd(2, 0);
    setPn(7); cmd(2, 0);
    chk("R5 gated by txEn", macValid, 0);
    chk("R5 queue filled", txqEmpty, 0);
    @(negedge clk); txEnSet = 1; @(negedge clk); txEnSet = 0;
    chk("R5 offered", macValid, 1);
    chk("R5 head order", macPkt, 5);
    @(negedge clk); chk("R5 held without ready", macPkt, 5);
    macReady = 1; @(negedge clk); macReady = 0;
    chk("R5 next entry", macPkt, 7);
    macReady = 1; @(negedge clk); macReady = 0;
    chk("R5 drained", macValid, 0);
    chk("R5 empty read", macPkt, 15);

    // R6 / R7 completion queue
    report(5, 1);
    chk("R6 head", compHead, 5);
    chk("R6 txFlag", txFlag, 1);
    txMask = 1; #1; chk("R10 txIrq", txIrq, 1);
    report(7, 1);
    chk("R6 head unchanged", compHead, 5);
    cmd(3, 0); chk("R7 pop to next", compHead, 7);
    cmd(3, 0); chk("R7 empty", compEmpty, 1);
    chk("R6 empty read", compHead, 15);
    chk("R6 flag clear", txFlag, 0);
    cmd(3, 0); chk("R7 ack on empty", compEmpty, 1);
    chk("R7 ack on empty head", compHead, 15);

    // R8 auto-release
    cmd(0, 300); @(negedge clk);
    chk("R8 setup grant", allocResult, 0);
    chk("R8 setup pages", freePages, 30);
    autoRelease = 1;
    report(0, 1);
    chk("R8 pages freed", freePages, 32);
    chk("R8 no completion", compEmpty, 1);

    // R9 failure path
    chk("R9 txEn before fail", txEn, 1);
    report(3, 0);
    chk("R9 txEn cleared", txEn, 0);
    chk("R9 failure queued", compHead, 3);
    txMask = 0; #1; chk("R10 txIrq masked", txIrq, 0);
    cmd(3, 0);
    @(negedge clk); txEnSet = 1; @(negedge clk); txEnSet = 0;
    chk("R9 txEn resumed", txEn, 1);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule